// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Controller

This block is the digital core of a processor supervisor. It drives a reset pair and a watchdog fault flag, reports the supply state, and gates a chip-enable. Its inputs are an already synchronized undervoltage indication, a watchdog strobe with its disable flag, a chip-enable, and an oscillator select with a second input that is either an external clock or a timeout-range select. The analog parts are outside the block: comparators, reference, battery switching, three-level sensing and the oscillator. They arrive as clean digital levels.

All delays are counted in ticks. A tick comes either from an internal divider of the system clock or from each rising edge of the external clock input. While undervoltage is reported, reset is asserted at once and the chip-enable output is forced inactive. After undervoltage clears, reset is held for a fixed number of ticks. The watchdog expects the strobe to change level within a timeout. When it does not, the block issues a fixed-length reset pulse and latches a fault flag. That flag stays low until the strobe next changes or undervoltage is reported.

Top module: `sup_reset_wdog`

## Requirements
- R1: While `lowv_i` is 1, `rst_no` is 0 in the same cycle, and extra ticks do not release it.
- R2: After `lowv_i` falls, or after `rst_ni` releases, `rst_no` stays 0 for exactly RST_TICKS ticks and then returns to 1.
- R3: With the watchdog enabled and reset inactive, WD timeout ticks without a strobe edge start a reset pulse of exactly RST_TICKS ticks and drive `wdo_no` to 0.
- R4: Every change of `wdi_i`, rising or falling, restarts the watchdog count from zero.
- R5: While `wd_dis_i` is 1, no watchdog timeout occurs and `wdo_no` is 1 (from the cycle after it is set).
- R6: Once `wdo_no` is 0, it returns to 1 on the next `wdi_i` change or when `lowv_i` goes to 1.
- R7: `rst_o` is always the inverse of `rst_no`. Both are asserted while `rst_ni` is 0.
- R8: `ce_n_o` equals `ce_n_i` while `lowv_i` is 0 and is 1 while `lowv_i` is 1, with no register.
- R9: With `osc_sel_i`=1, a tick occurs every INT_DIV clock cycles. The timeout is WD_FAST_TICKS if `osc_in_i`=0 and WD_SLOW_TICKS if `osc_in_i`=1. With `osc_sel_i`=0, each rising edge of `osc_in_i` is one tick and the timeout is WD_SLOW_TICKS.
- R10: `low_line_no` is the inverse of `lowv_i` with no added delay.
- R11: The watchdog count is held at zero while reset is asserted, and a full timeout starts when reset releases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lowv_i | input | 1 | Undervoltage indication, 1 = supply low |
| wdi_i | input | 1 | Watchdog strobe, asynchronous |
| wd_dis_i | input | 1 | 1 disables the watchdog |
| ce_n_i | input | 1 | Active-low chip-enable in |
| osc_sel_i | input | 1 | 1 = internal tick, 0 = external clock |
| osc_in_i | input | 1 | External clock, or timeout range select in internal mode |
| rst_no | output | 1 | Active-low reset |
| rst_o | output | 1 | Active-high reset |
| wdo_no | output | 1 | Active-low watchdog fault |
| low_line_no | output | 1 | Active-low undervoltage flag |
| ce_n_o | output | 1 | Gated active-low chip-enable |

## Verification
The bench uses external-clock mode to step the design one tick at a time. It checks the release point of each reset hold on both sides of the boundary, at RST_TICKS-1 ticks and at RST_TICKS ticks, and the expiry of the watchdog at timeout-1 ticks and at timeout ticks. An off-by-one counter, or a pulse that restarts or never ends, shows up at these points. Strobe edges in both directions are placed one tick before expiry, so a design that restarts only on rising edges fires a reset. The bench also confirms that the fault flag survives the reset pulse, clears on a strobe edge or on undervoltage, and stays high while the watchdog is disabled. In internal mode it measures the hold and both timeout ranges in clock cycles, which would expose a swapped fast/slow select or a wrong divider.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic {TICK_EXT = 1'b0, TICK_INT = 1'b1} tick_src_e;
endpackage

// File: rtl/sup_sync.sv
module sup_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic prev_o
);
  logic [2:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[1:0], d_i};
  end
  assign q_o    = sh_q[1];
  assign prev_o = sh_q[2];
endmodule

// File: rtl/sup_tick.sv
module sup_tick
  import sup_pkg::*;
#(
  parameter int INT_DIV = 1000
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  tick_src_e src_i,
  input  logic      ext_rise_i,
  output logic      tick_o
);
  localparam int DW = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam logic [DW-1:0] DIV_MAX = DW'(INT_DIV - 1);

  logic [DW-1:0] div_q;
  logic          wrap;

  assign wrap = (div_q == DIV_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (wrap) div_q <= '0;
    else           div_q <= div_q + 1'b1;
  end

  assign tick_o = (src_i == TICK_INT) ? wrap : ext_rise_i;

  a_r9_div_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_q <= DIV_MAX);
endmodule

// File: rtl/sup_rst_timer.sv
module sup_rst_timer #(
  parameter int RST_TICKS = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_i,
  input  logic trig_i,
  input  logic tick_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(RST_TICKS - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  // power-up behaves like a low-line release: full hold
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (low_i || trig_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && tick_i) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy_o = busy_q;

  a_r2_hold_after_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(low_i) |-> busy_q);
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  a_r3_trig_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> (busy_q && cnt_q == '0));
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int WD_FAST_TICKS = 100,
  parameter int WD_SLOW_TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  input  logic dis_i,
  input  logic low_i,
  input  logic tog_i,
  input  logic tick_i,
  input  logic slow_i,
  output logic expire_o,
  output logic wdo_no
);
  localparam int CW = $clog2(WD_SLOW_TICKS + 1);
  localparam logic [CW-1:0] LIM_F = CW'(WD_FAST_TICKS - 1);
  localparam logic [CW-1:0] LIM_S = CW'(WD_SLOW_TICKS - 1);

  logic [CW-1:0] wcnt_q;
  logic [CW-1:0] lim;
  logic          wdo_q;
  logic          at_lim;

  assign lim    = slow_i ? LIM_S : LIM_F;
  // >= so a range switch mid-count cannot overrun
  assign at_lim = (wcnt_q >= lim);
  assign expire_o = tick_i && at_lim && !hold_i && !dis_i && !tog_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wcnt_q <= '0;
    else if (hold_i || tog_i || dis_i)   wcnt_q <= '0;
    else if (tick_i)                     wcnt_q <= at_lim ? '0 : wcnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         wdo_q <= 1'b1;
    else if (low_i || tog_i || dis_i)    wdo_q <= 1'b1;
    else if (expire_o)                   wdo_q <= 1'b0;
  end

  assign wdo_no = wdo_q;

  a_r11_no_expire_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |-> !expire_o);
  a_r11_cleared_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(hold_i) |-> (wcnt_q == '0));
  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wcnt_q <= LIM_S);
  a_r3_fault_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> !wdo_q);
  a_r5_dis_keeps_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(dis_i) |-> wdo_q);
  a_r6_edge_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tog_i |=> wdo_q);
endmodule

// File: rtl/sup_reset_wdog.sv
module sup_reset_wdog
  import sup_pkg::*;
#(
  parameter int INT_DIV       = 1000,
  parameter int RST_TICKS     = 50,
  parameter int WD_FAST_TICKS = 100,
  parameter int WD_SLOW_TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lowv_i,
  input  logic wdi_i,
  input  logic wd_dis_i,
  input  logic ce_n_i,
  input  logic osc_sel_i,
  input  logic osc_in_i,
  output logic rst_no,
  output logic rst_o,
  output logic wdo_no,
  output logic low_line_no,
  output logic ce_n_o
);
  logic      wdi_q, wdi_p, osc_q, osc_p;
  logic      wdi_tog, osc_rise, tick;
  logic      busy, expire, rst_act;
  tick_src_e src;

  sup_sync u_wdi_sync (.clk_i, .rst_ni, .d_i(wdi_i),    .q_o(wdi_q), .prev_o(wdi_p));
  sup_sync u_osc_sync (.clk_i, .rst_ni, .d_i(osc_in_i), .q_o(osc_q), .prev_o(osc_p));

  assign wdi_tog  = wdi_q ^ wdi_p;
  assign osc_rise = osc_q & ~osc_p;
  assign src      = osc_sel_i ? TICK_INT : TICK_EXT;

  sup_tick #(.INT_DIV(INT_DIV)) u_tick (
    .clk_i, .rst_ni, .src_i(src), .ext_rise_i(osc_rise), .tick_o(tick)
  );

  sup_rst_timer #(.RST_TICKS(RST_TICKS)) u_rst (
    .clk_i, .rst_ni, .low_i(lowv_i), .trig_i(expire), .tick_i(tick), .busy_o(busy)
  );

  assign rst_act = busy | lowv_i;

  sup_wdog #(.WD_FAST_TICKS(WD_FAST_TICKS), .WD_SLOW_TICKS(WD_SLOW_TICKS)) u_wd (
    .clk_i, .rst_ni, .hold_i(rst_act), .dis_i(wd_dis_i), .low_i(lowv_i),
    .tog_i(wdi_tog), .tick_i(tick), .slow_i(~osc_sel_i | osc_q),
    .expire_o(expire), .wdo_no(wdo_no)
  );

  assign rst_no      = ~rst_act;
  assign rst_o       = rst_act;
  assign low_line_no = ~lowv_i;
  assign ce_n_o      = ce_n_i | lowv_i;

  a_r1_low_forces_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_i |-> (!rst_no && rst_o));
  a_r8_ce_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lowv_i |-> ce_n_o);
  a_r7_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o != rst_no);
endmodule

// File: tb/sim_sup_reset_wdog.sv
module sim_sup_reset_wdog;
  localparam int DIV = 4, RT = 5, WF = 3, WS = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lowv = 0, wdi = 0, wd_dis = 0, ce_n = 1, osc_sel = 0, osc = 0;
  logic rst_no, rst_o, wdo_no, low_line_no, ce_n_o;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  sup_reset_wdog #(.INT_DIV(DIV), .RST_TICKS(RT), .WD_FAST_TICKS(WF), .WD_SLOW_TICKS(WS)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .lowv_i(lowv), .wdi_i(wdi), .wd_dis_i(wd_dis),
    .ce_n_i(ce_n), .osc_sel_i(osc_sel), .osc_in_i(osc),
    .rst_no, .rst_o, .wdo_no, .low_line_no, .ce_n_o
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_rng(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      osc = 1'b1; cyc(4);
      osc = 1'b0; cyc(4);
    end
  endtask

  task automatic flip_wdi();
    wdi = ~wdi; cyc(4);
  endtask

  task automatic run_until(input logic lvl, output int n);
    n = 0;
    while (rst_no !== lvl && n < 2000) begin cyc(1); n++; end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    cyc(3);
    // R7 reset state
    chk("R7 rst_no in reset", rst_no, 1'b0);
    chk("R7 rst_o in reset", rst_o, 1'b1);
    chk("R6 wdo idle", wdo_no, 1'b1);
    chk("R10 low_line idle", low_line_no, 1'b1);
    rst_n = 1'b1; cyc(2);
    // R2 power-up hold, external ticks
    ticks(RT - 1); chk("R2 hold before last tick", rst_no, 1'b0);
    ticks(1);      chk("R2 release after RT ticks", rst_no, 1'b1);
    chk("R7 inverse", rst_o, 1'b0);
    // R11 / R3 timeout from fresh start
    ticks(WS - 1); chk("R11 no early expire", rst_no, 1'b1);
    ticks(1);      chk("R3 expire resets", rst_no, 1'b0);
    chk("R3 fault low", wdo_no, 1'b0);
    ticks(RT - 1); chk("R3 pulse holds", rst_no, 1'b0);
    ticks(1);      chk("R3 pulse ends", rst_no, 1'b1);
    chk("R6 fault persists", wdo_no, 1'b0);
    flip_wdi();    chk("R6 edge clears fault", wdo_no, 1'b1);
    // R4 both edge directions restart
    ticks(WS - 1); flip_wdi();
    ticks(WS - 1); flip_wdi();
    ticks(WS - 1);
    chk("R4 restart keeps reset off", rst_no, 1'b1);
    chk("R4 no fault", wdo_no, 1'b1);
    ticks(1);      chk("R4 count continues to expire", rst_no, 1'b0);
    ticks(RT);     chk("R3 second pulse ends", rst_no, 1'b1);
    // R1 / R6 / R8 / R10 low-line
    lowv = 1'b1; #1;
    chk("R1 immediate reset", rst_no, 1'b0);
    chk("R10 immediate flag", low_line_no, 1'b0);
    ce_n = 1'b0; #1;
    chk("R8 ce forced high", ce_n_o, 1'b1);
    cyc(2);
    chk("R6 lowv clears fault", wdo_no, 1'b1);
    ticks(RT + 5); chk("R1 ticks do not release", rst_no, 1'b0);
    lowv = 1'b0; #1;
    chk("R10 immediate recovery", low_line_no, 1'b1);
    chk("R8 ce follows 0", ce_n_o, 1'b0);
    chk("R2 still held", rst_no, 1'b0);
    ce_n = 1'b1; #1;
    chk("R8 ce follows 1", ce_n_o, 1'b1);
    cyc(1);
    ticks(RT - 1); chk("R2 low-line hold", rst_no, 1'b0);
    ticks(1);      chk("R2 low-line release", rst_no, 1'b1);
    // R5 disable
    ticks(WS - 1); chk("R11 fresh after release", rst_no, 1'b1);
    ticks(1);      chk("R3 expire again", rst_no, 1'b0);
    wd_dis = 1'b1; cyc(2);
    chk("R5 disable lifts fault", wdo_no, 1'b1);
    ticks(RT + 3 * WS);
    chk("R5 no timeout while disabled", rst_no, 1'b1);
    chk("R5 fault high while disabled", wdo_no, 1'b1);
    wd_dis = 1'b0;
    // R9 internal tick, fast then slow
    osc_sel = 1'b1; osc = 1'b0;
    rst_n = 1'b0; cyc(2); rst_n = 1'b1;
    run_until(1'b1, n); chk_rng("R9 internal hold cycles", n, (RT - 1) * DIV + 1, (RT + 1) * DIV);
    run_until(1'b0, n); chk_rng("R9 fast timeout cycles", n, (WF - 1) * DIV + 1, (WF + 1) * DIV);
    osc = 1'b1;
    run_until(1'b1, n);
    run_until(1'b0, n); chk_rng("R9 slow timeout cycles", n, (WS - 1) * DIV + 1, (WS + 1) * DIV);
    chk("R3 internal fault", wdo_no, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule